// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves data between two 8-bit ports, A and B, and holds it in two separate storage banks. One bank captures from port A and presents its contents toward port B. The other captures from port B and presents toward port A. Each direction has three active-low controls: a chip enable, a latch enable and an output enable. The latch enable and the output enable only act while that direction's chip enable is low.

The core uses no tristate. Each port has an input bus, a data-out bus and a single drive-enable bit, so a pad wrapper can build real bidirectional pins. The block is written for a clocked fabric. A "transparent" bank therefore copies its source port on every rising clock edge, and it freezes as soon as either its chip enable or its latch enable goes high. A synchronous clear sets both banks to zero so that simulation starts from a known state.

The block also raises a contention flag when it drives a port while an external agent says it is driving that same port.

Top module: `latched_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both banks are set to zero, `a_oe`, `b_oe` and `contention` go low, and `a_out` and `b_out` read zero after that edge.
- R2: At an edge where a direction's chip enable is high, that bank keeps its value, whatever its latch enable is. After that edge its drive-enable output is low, whatever its output enable is.
- R3: At an edge where a direction's chip enable and latch enable are both low, the bank loads its source port. The new value appears on the opposite port's data-out bus after that same edge (`b_out` for A-to-B, `a_out` for B-to-A).
- R4: At an edge where the chip enable is low and the latch enable is high, the bank keeps its previous value, even when the source port changes.
- R5: After an edge, a drive-enable output (`b_oe` for A-to-B, `a_oe` for B-to-A) is 1, meaning drive, only if that direction's chip enable and output enable were both low at that edge. Otherwise it is 0, meaning high impedance. The data-out bus always shows the bank contents.
- R6: The two directions are independent. Both banks can store at the same edge, and one bank can be transparent while the other bank drives.
- R7: `contention` goes high after an edge where either `a_oe` was high together with `a_ext_drv`, or `b_oe` was high together with `b_ext_drv`. After any other edge it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| a_in | input | 8 | Value sensed on port A |
| a_out | output | 8 | Value to place on port A (B-to-A bank contents) |
| a_oe | output | 1 | 1 = drive port A, 0 = high impedance |
| b_in | input | 8 | Value sensed on port B |
| b_out | output | 8 | Value to place on port B (A-to-B bank contents) |
| b_oe | output | 1 | 1 = drive port B, 0 = high impedance |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_ext_drv | input | 1 | An external agent is driving port A |
| b_ext_drv | input | 1 | An external agent is driving port B |
| contention | output | 1 | Registered clash flag |

## Verification
The assertions check the per-edge rules on every cycle:
- a bank holds when its chip enable is high or its latch enable is high;
- a transparent bank loads its source;
- a disabled direction stops driving;
- the clear takes effect;
- the contention flag follows the drive and external-drive conditions.

Some behaviour shows only in the bench scenarios, which run a cycle model as a scoreboard. These cover the pairing of the two directions at the same time, such as storing in both banks at once or driving one port while the other bank is transparent. They also cover a value that must survive several later changes on its source port, and every row of the control table for both directions.

// File: rtl/latched_xcvr_pkg.sv
package latched_xcvr_pkg;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam int N_DIR  = 2;

  // Active-low controls of one transfer direction
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_dir_bank.sv
module xcvr_dir_bank
  import latched_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctrl_t    ctrl,
  input  logic [W-1:0] src,
  output logic [W-1:0] held,
  output logic         drive
);
  logic open_q;
  logic drive_d;

  always_comb begin
    open_q  = !ctrl.ce_n && !ctrl.le_n;
    drive_d = !ctrl.ce_n && !ctrl.oe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      drive <= 1'b0;
    end else begin
      if (open_q) held <= src;
      drive <= drive_d;
    end
  end

  // R1: clear empties the bank and turns the driver off
  p_clear_r1: assert property (@(posedge clk) rst |=> (held == '0) && !drive);

  // R2: chip enable high freezes the bank and turns the driver off
  p_ce_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.ce_n |=> $stable(held) && !drive);

  // R3: a transparent bank takes its source value
  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.ce_n && !ctrl.le_n) |=> held == $past(src));

  // R4: latch enable high keeps the stored value
  p_le_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.ce_n && ctrl.le_n) |=> $stable(held));

  // R5: output enable high means high impedance
  p_hiz_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl.oe_n |=> !drive);
endmodule

// File: rtl/xcvr_clash.sv
module xcvr_clash #(
  parameter int N_PORT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PORT-1:0] own_drv,
  input  logic [N_PORT-1:0] ext_drv,
  output logic              flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= |(own_drv & ext_drv);
  end
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import latched_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_ce_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n,
  input  logic         a_ext_drv,
  input  logic         b_ext_drv,
  output logic         contention
);
  dir_ctrl_t [N_DIR-1:0]        ctrl;
  logic      [N_DIR-1:0][W-1:0] src;
  logic      [N_DIR-1:0][W-1:0] held;
  logic      [N_DIR-1:0]        drv;

  always_comb begin
    ctrl[DIR_AB] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
    ctrl[DIR_BA] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};
    src[DIR_AB]  = a_in;
    src[DIR_BA]  = b_in;
  end

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    xcvr_dir_bank #(.W(W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl[g]),
      .src   (src[g]),
      .held  (held[g]),
      .drive (drv[g])
    );
  end

  assign b_out = held[DIR_AB];
  assign b_oe  = drv[DIR_AB];
  assign a_out = held[DIR_BA];
  assign a_oe  = drv[DIR_BA];

  xcvr_clash #(.N_PORT(2)) u_clash (
    .clk     (clk),
    .rst     (rst),
    .own_drv ({b_oe, a_oe}),
    .ext_drv ({b_ext_drv, a_ext_drv}),
    .flag    (contention)
  );

  // R7: driving a port that is also driven from outside raises the flag
  p_clash_r7: assert property (@(posedge clk) disable iff (rst)
    ((a_oe && a_ext_drv) || (b_oe && b_ext_drv)) |=> contention);

  // R7: with no overlap the flag stays low
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!(a_oe && a_ext_drv) && !(b_oe && b_ext_drv)) |=> !contention);

  // R6: one direction's controls do not move the other bank
  p_indep_r6: assert property (@(posedge clk) disable iff (rst)
    (ab_ce_n && ba_ce_n) |=> $stable(a_out) && $stable(b_out));
endmodule

// File: tb/latched_xcvr_test.sv
`timescale 1ns/1ps
module latched_xcvr_test;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] a_out;
    logic         a_oe;
    logic [W-1:0] b_out;
    logic         b_oe;
    logic         flag;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, contention;
  logic ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic a_ext_drv = 1'b0, b_ext_drv = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  exp_t q[$];

  // model state
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic m_aoe = 0, m_boe = 0, m_flag = 0;

  always #2.5 clk = ~clk;

  latched_xcvr #(.W(W)) uut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_ext_drv(a_ext_drv), .b_ext_drv(b_ext_drv),
    .contention(contention)
  );

  // driver: one clock edge, model update, push the expected outputs
  task automatic step(input string tag);
    exp_t e;
    logic nf;
    @(posedge clk);
    if (rst) begin
      m_ab = '0; m_ba = '0; m_aoe = 0; m_boe = 0; m_flag = 0;
    end else begin
      nf = (m_aoe && a_ext_drv) || (m_boe && b_ext_drv);
      if (!ab_ce_n && !ab_le_n) m_ab = a_in;
      if (!ba_ce_n && !ba_le_n) m_ba = b_in;
      m_boe  = !ab_ce_n && !ab_oe_n;
      m_aoe  = !ba_ce_n && !ba_oe_n;
      m_flag = nf;
    end
    e.a_out = m_ba; e.a_oe = m_aoe; e.b_out = m_ab; e.b_oe = m_boe;
    e.flag = m_flag; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic set_ab(input logic ce, input logic le, input logic oe);
    ab_ce_n = ce; ab_le_n = le; ab_oe_n = oe;
  endtask

  task automatic set_ba(input logic ce, input logic le, input logic oe);
    ba_ce_n = ce; ba_le_n = le; ba_oe_n = oe;
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out ||
          b_oe !== e.b_oe || contention !== e.flag) begin
        errors++;
        $display("FAIL %s: got a_out=%h a_oe=%b b_out=%h b_oe=%b flag=%b, exp a_out=%h a_oe=%b b_out=%h b_oe=%b flag=%b",
                 e.tag, a_out, a_oe, b_out, b_oe, contention,
                 e.a_out, e.a_oe, e.b_out, e.b_oe, e.flag);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: clear with every control asking to store and drive
    set_ab(0, 0, 0); set_ba(0, 0, 0); a_in = 8'hA5; b_in = 8'h3C;
    a_ext_drv = 1; b_ext_drv = 1;
    step("R1 reset");
    step("R1 reset hold");
    rst = 0; set_ab(1, 1, 1); set_ba(1, 1, 1); a_ext_drv = 0; b_ext_drv = 0;
    step("R1 idle after reset");

    // R3: A-to-B transparent, several patterns
    set_ab(0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      a_in = 8'h11 << i ^ 8'hF0; step("R3 a-to-b follow");
    end
    // R4: freeze, then change a_in
    a_in = 8'h5A; step("R3 load 5A");
    set_ab(0, 1, 1); a_in = 8'hFF; step("R4 a-to-b frozen");
    a_in = 8'h00; step("R4 a-to-b frozen 2");
    // R5: drive the stored value
    set_ab(0, 1, 0); step("R5 b drive on");
    a_in = 8'h77; step("R5 b drive keeps 5A");
    set_ab(0, 1, 1); step("R5 oe high releases b");
    // R2: chip enable high, other controls low
    set_ab(1, 0, 0); a_in = 8'hC3; step("R2 ce high blocks store and drive");
    step("R2 ce high again");
    set_ab(1, 1, 0); step("R2 ce high le high");

    // B-to-A mirror
    set_ba(0, 0, 1); b_in = 8'h96; step("R3 b-to-a follow");
    b_in = 8'h69; step("R3 b-to-a follow 2");
    set_ba(0, 1, 0); b_in = 8'h00; step("R4 b-to-a frozen, R5 a driven");
    set_ba(1, 0, 0); b_in = 8'hEE; step("R2 b-to-a ce high");
    set_ba(1, 1, 1); step("R2 b-to-a idle");

    // R6: both banks store at once
    set_ab(0, 0, 1); set_ba(0, 0, 1); a_in = 8'h12; b_in = 8'h34;
    step("R6 both store");
    set_ab(0, 1, 1); set_ba(0, 1, 1); a_in = 8'h99; b_in = 8'h88;
    step("R6 both frozen");
    // R6: A-to-B drives port B while B-to-A is transparent
    set_ab(0, 1, 0); set_ba(0, 0, 1); b_in = 8'hAB;
    step("R6 drive b, ba transparent");
    b_in = 8'hCD; step("R6 drive b, ba follows");
    set_ab(0, 0, 0); set_ba(0, 1, 0); a_in = 8'h4E;
    step("R6 both drive, ab transparent");

    // R7: contention
    b_ext_drv = 1; step("R7 b clash seen");
    step("R7 b clash flagged");
    b_ext_drv = 0; a_ext_drv = 1; step("R7 a clash");
    set_ba(0, 1, 1); step("R7 a released");
    step("R7 flag clears");
    a_ext_drv = 0; b_ext_drv = 0; set_ab(1, 1, 1); set_ba(1, 1, 1);
    step("R7 quiet");
    step("R7 quiet 2");

    // R1: clear again mid-run
    rst = 1; step("R1 mid reset");
    rst = 0; step("R1 after mid reset");
    @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule